// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads a fixed-length configuration word over a slow serial link after power comes up and turns it into decoded settings for the rest of the chip. It divides the system clock down to a mode clock, which it drives out to the external source of the configuration bits. One bit is taken on each rising mode-clock edge, starting with the first edge after the power-good input is seen high. When all 256 bits are in, the block raises a done flag and presents these decoded fields:

- writeback data pattern
- clock multiplier
- byte order
- write protocol
- timer-interrupt disable
- bus width
- driver strength

An error flag reports any reserved bit that is set, and any reserved code in a field.

A three-state controller sequences the load. `ST_IDLE` is the state after reset. It moves to `ST_LOAD` when `pwr_good` is high (transition *power_ok*). `ST_LOAD` takes one bit on each rising mode-clock edge. It moves to `ST_DONE` on the edge that takes the last bit (transition *last_bit*). `ST_DONE` holds until reset (transition *hold*). The mode clock never stops, but no bit is taken outside `ST_LOAD`. Only the 15 field bits are stored. A single sticky flag stands for bits 15 through 255.

The source must hold each bit stable for at least 3 system-clock cycles before the rising mode-clock edge that samples it. No hold time is needed after that edge.

Top module: `boot_cfg_loader`

## Requirements
- R1: `mode_clk` is the system clock divided by 2^DIV_LOG2 (256 by default), with a 50% duty cycle. It is low out of reset and first rises 2^(DIV_LOG2-1) clock edges after reset is released. It keeps toggling in every state, including after the load is done.
- R2: No bit is sampled while `pwr_good` has not been seen high. Bit 0 is the value of `mode_in` at the first rising mode-clock edge after the controller has entered `ST_LOAD`.
- R3: Exactly CFG_BITS (256) bits are read. The first bit received is bit 0 and the last is bit 255. `cfg_done` rises on the same system-clock edge on which `mode_clk` rises to sample bit 255.
- R4: Once `cfg_done` is high, changes on `mode_in` have no effect. `cfg_done` and every decoded output hold their values until reset.
- R5: After loading completes, the fields are decoded as follows:
  - `wb_pattern` = bits 4..1
  - `big_endian` = bit 8 (0 little, 1 big)
  - `wr_proto` = bits 10..9 (00 legacy-compatible, 10 pipelined writes, 11 write re-issue)
  - `timer_int_off` = bit 11
  - `bus_narrow` = bit 12 (0 = 64-bit, 1 = 32-bit)
- R6: `clk_ratio` is the 3-bit code in bits 7..5 plus 2 for codes 0 to 6, giving 2 to 8. It is 0 for the reserved code 7.
- R7: `drive_pct` decodes bits 14..13 as follows: 10 gives 100, 11 gives 83, 00 gives 67 and 01 gives 50.
- R8: When done, `cfg_error` is 1 if any of the following is true, and 0 otherwise:
  - bit 0 is 1
  - any of bits 255..15 is 1
  - bits 4..1 exceed 8
  - bits 7..5 equal 7
  - bits 10..9 equal 01
- R9: While `cfg_done` is low, including right after reset, `cfg_done`, `cfg_error` and every decoded output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; a high level starts the load |
| mode_in | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Divided mode clock; bits are sampled on its rising edge |
| cfg_done | output | 1 | All configuration bits have been loaded |
| cfg_error | output | 1 | A reserved bit or a reserved code was loaded |
| wb_pattern | output | 4 | Writeback data pattern code |
| clk_ratio | output | 4 | Clock multiplier (2 to 8), 0 if the code is reserved |
| big_endian | output | 1 | 1 = big-endian byte order |
| wr_proto | output | 2 | Write protocol code |
| timer_int_off | output | 1 | 1 = timer interrupt disabled |
| bus_narrow | output | 1 | 1 = 32-bit bus, 0 = 64-bit bus |
| drive_pct | output | 7 | Driver strength in percent |

## Verification
Each bit is due at the rising mode-clock edge that follows the falling mode-clock edge at which the bench changes `mode_in`, which leaves half a mode period of setup time. The bench checks that `cfg_done` is still low one half-cycle after bit 255 is driven, and high at the first falling clock edge after the next mode-clock rise. The decoded fields and the error flag are due on that same edge. The scoreboard monitor therefore compares them at the falling clock edge after `cfg_done` rises. The mode-clock period and high time are measured in clock periods on a default-parameter instance. The ignore-after-done check samples the outputs at falling clock edges while `mode_in` is toggled over four mode periods.

// File: rtl/bcl_pkg.sv
package bcl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_DONE = 2'd2
    } bcl_state_e;

    // Number of low-order bits that carry fields; all bits above are reserved.
    localparam int FIELD_BITS = 15;

    localparam int RSV_BIT = 0;
    localparam int WB_LO   = 1;
    localparam int WB_HI   = 4;
    localparam int MUL_LO  = 5;
    localparam int MUL_HI  = 7;
    localparam int END_BIT = 8;
    localparam int WP_LO   = 9;
    localparam int WP_HI   = 10;
    localparam int TMR_BIT = 11;
    localparam int BUS_BIT = 12;
    localparam int DRV_LO  = 13;
    localparam int DRV_HI  = 14;

    localparam logic [3:0] WB_MAX_CODE  = 4'd8;
    localparam logic [2:0] MUL_RSV_CODE = 3'd7;
    localparam logic [1:0] WP_RSV_CODE  = 2'b01;

endpackage

// File: rtl/bcl_mode_clk.sv
module bcl_mode_clk #(
    parameter int DIV_LOG2 = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mode_clk,
    output logic rise_tick
);
    // rise_tick is high in the cycle whose closing edge raises mode_clk.
    localparam logic [DIV_LOG2-1:0] RISE_AT = {1'b0, {(DIV_LOG2-1){1'b1}}};

    logic [DIV_LOG2-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign mode_clk  = div_cnt[DIV_LOG2-1];
    assign rise_tick = (div_cnt == RISE_AT);

endmodule

// File: rtl/bcl_capture.sv
module bcl_capture #(
    parameter int CFG_BITS   = 256,
    parameter int FIELD_BITS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cap_en,
    input  logic                  mode_in,
    output logic [FIELD_BITS-1:0] field_q,
    output logic                  high_resv,
    output logic                  last_bit
);
    localparam int IDX_W = $clog2(CFG_BITS);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(CFG_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_FIRST_RSV = IDX_W'(FIELD_BITS);

    logic [IDX_W-1:0] bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
        end else if (cap_en) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // One storage bit per field position, each loaded when its index arrives.
    for (genvar g = 0; g < FIELD_BITS; g++) begin : g_field
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[g] <= 1'b0;
            end else if (cap_en && (bit_idx == IDX_W'(g))) begin
                field_q[g] <= mode_in;
            end
        end
    end

    // Reserved upper bits collapse into a single sticky flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_resv <= 1'b0;
        end else if (cap_en && (bit_idx >= IDX_FIRST_RSV) && mode_in) begin
            high_resv <= 1'b1;
        end
    end

    assign last_bit = cap_en && (bit_idx == IDX_LAST);

endmodule

// File: rtl/bcl_decode.sv
module bcl_decode
    import bcl_pkg::*;
(
    input  logic [FIELD_BITS-1:0] field_q,
    input  logic                  high_resv,
    output logic [3:0]            wb_pattern,
    output logic [3:0]            clk_ratio,
    output logic                  big_endian,
    output logic [1:0]            wr_proto,
    output logic                  timer_int_off,
    output logic                  bus_narrow,
    output logic [6:0]            drive_pct,
    output logic                  cfg_error
);
    logic [2:0] mul_code;
    logic [1:0] drv_code;

    assign mul_code      = field_q[MUL_HI:MUL_LO];
    assign drv_code      = field_q[DRV_HI:DRV_LO];
    assign wb_pattern    = field_q[WB_HI:WB_LO];
    assign big_endian    = field_q[END_BIT];
    assign wr_proto      = field_q[WP_HI:WP_LO];
    assign timer_int_off = field_q[TMR_BIT];
    assign bus_narrow    = field_q[BUS_BIT];

    always_comb begin
        if (mul_code == MUL_RSV_CODE) begin
            clk_ratio = 4'd0;
        end else begin
            clk_ratio = {1'b0, mul_code} + 4'd2;
        end
    end

    always_comb begin
        unique case (drv_code)
            2'b10:   drive_pct = 7'd100;
            2'b11:   drive_pct = 7'd83;
            2'b00:   drive_pct = 7'd67;
            default: drive_pct = 7'd50;
        endcase
    end

    assign cfg_error = field_q[RSV_BIT]
                     | high_resv
                     | (field_q[WB_HI:WB_LO] > WB_MAX_CODE)
                     | (mul_code == MUL_RSV_CODE)
                     | (field_q[WP_HI:WP_LO] == WP_RSV_CODE);

endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
    import bcl_pkg::*;
#(
    parameter int DIV_LOG2 = 8,
    parameter int CFG_BITS = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    input  logic       mode_in,
    output logic       mode_clk,
    output logic       cfg_done,
    output logic       cfg_error,
    output logic [3:0] wb_pattern,
    output logic [3:0] clk_ratio,
    output logic       big_endian,
    output logic [1:0] wr_proto,
    output logic       timer_int_off,
    output logic       bus_narrow,
    output logic [6:0] drive_pct
);
    bcl_state_e state, state_nxt;

    logic                  rise_tick;
    logic                  cap_en;
    logic                  last_bit;
    logic                  high_resv;
    logic [FIELD_BITS-1:0] field_q;

    logic       dec_error;
    logic [3:0] dec_wb;
    logic [3:0] dec_ratio;
    logic       dec_be;
    logic [1:0] dec_proto;
    logic       dec_tmr;
    logic       dec_bus;
    logic [6:0] dec_pct;

    bcl_mode_clk #(.DIV_LOG2(DIV_LOG2)) u_mclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_clk  (mode_clk),
        .rise_tick (rise_tick)
    );

    assign cap_en = (state == ST_LOAD) && rise_tick;

    bcl_capture #(.CFG_BITS(CFG_BITS), .FIELD_BITS(FIELD_BITS)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_en),
        .mode_in   (mode_in),
        .field_q   (field_q),
        .high_resv (high_resv),
        .last_bit  (last_bit)
    );

    bcl_decode u_dec (
        .field_q       (field_q),
        .high_resv     (high_resv),
        .wb_pattern    (dec_wb),
        .clk_ratio     (dec_ratio),
        .big_endian    (dec_be),
        .wr_proto      (dec_proto),
        .timer_int_off (dec_tmr),
        .bus_narrow    (dec_bus),
        .drive_pct     (dec_pct),
        .cfg_error     (dec_error)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: power_ok, last_bit, hold
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (pwr_good) state_nxt = ST_LOAD;
            ST_LOAD: if (last_bit) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_DONE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs: everything is held at zero until the load is complete
    always_comb begin
        cfg_done      = 1'b0;
        cfg_error     = 1'b0;
        wb_pattern    = '0;
        clk_ratio     = '0;
        big_endian    = 1'b0;
        wr_proto      = '0;
        timer_int_off = 1'b0;
        bus_narrow    = 1'b0;
        drive_pct     = '0;
        if (state == ST_DONE) begin
            cfg_done      = 1'b1;
            cfg_error     = dec_error;
            wb_pattern    = dec_wb;
            clk_ratio     = dec_ratio;
            big_endian    = dec_be;
            wr_proto      = dec_proto;
            timer_int_off = dec_tmr;
            bus_narrow    = dec_bus;
            drive_pct     = dec_pct;
        end
    end

endmodule

// File: rtl/boot_cfg_loader_chk.sv
module boot_cfg_loader_chk #(
    parameter int DIV_LOG2 = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_clk,
    input logic       cfg_done,
    input logic       cfg_error,
    input logic [3:0] wb_pattern,
    input logic [3:0] clk_ratio,
    input logic       big_endian,
    input logic [1:0] wr_proto,
    input logic       timer_int_off,
    input logic       bus_narrow,
    input logic [6:0] drive_pct
);
    localparam int HALF = 1 << (DIV_LOG2 - 1);
    localparam logic [DIV_LOG2-1:0] HALF_M1 = DIV_LOG2'(HALF - 1);

    // Independent half-period counter for the mode-clock window.
    logic [DIV_LOG2-1:0] half_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_cnt <= '0;
        end else if (half_cnt == HALF_M1) begin
            half_cnt <= '0;
        end else begin
            half_cnt <= half_cnt + 1'b1;
        end
    end

    a_r1_toggle_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        (half_cnt == HALF_M1) |=> (mode_clk != $past(mode_clk)));

    a_r1_steady_between: assert property (@(posedge clk) disable iff (!rst_n)
        (half_cnt != HALF_M1) |=> $stable(mode_clk));

    a_r3_done_on_mode_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $rose(mode_clk));

    a_r4_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && $stable({cfg_error, wb_pattern, clk_ratio, big_endian,
                                           wr_proto, timer_int_off, bus_narrow, drive_pct})));

    a_r9_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> (!cfg_error && (wb_pattern == 4'd0) && (clk_ratio == 4'd0) &&
                       !big_endian && (wr_proto == 2'd0) && !timer_int_off &&
                       !bus_narrow && (drive_pct == 7'd0)));

    a_r8_wb_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && (wb_pattern > 4'd8)) |-> cfg_error);

    a_r6_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && (clk_ratio != 4'd0)) |-> ((clk_ratio >= 4'd2) && (clk_ratio <= 4'd8)));

endmodule

bind boot_cfg_loader boot_cfg_loader_chk #(.DIV_LOG2(DIV_LOG2)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_clk      (mode_clk),
    .cfg_done      (cfg_done),
    .cfg_error     (cfg_error),
    .wb_pattern    (wb_pattern),
    .clk_ratio     (clk_ratio),
    .big_endian    (big_endian),
    .wr_proto      (wr_proto),
    .timer_int_off (timer_int_off),
    .bus_narrow    (bus_narrow),
    .drive_pct     (drive_pct)
);

// File: tb/boot_cfg_loader_tb.sv
module boot_cfg_loader_tb;

    localparam int FAST_LOG2 = 4;
    localparam int NBITS     = 256;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n    = 1'b0;
    logic pwr_good = 1'b0;
    logic mode_in  = 1'b0;

    logic       d_mclk, d_done, d_err, d_be, d_tmr, d_bus;
    logic [3:0] d_wb, d_ratio;
    logic [1:0] d_proto;
    logic [6:0] d_pct;

    logic       r_mclk, r_done, r_err, r_be, r_tmr, r_bus;
    logic [3:0] r_wb, r_ratio;
    logic [1:0] r_proto;
    logic [6:0] r_pct;

    boot_cfg_loader #(.DIV_LOG2(FAST_LOG2), .CFG_BITS(NBITS)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_in(mode_in),
        .mode_clk(d_mclk), .cfg_done(d_done), .cfg_error(d_err),
        .wb_pattern(d_wb), .clk_ratio(d_ratio), .big_endian(d_be),
        .wr_proto(d_proto), .timer_int_off(d_tmr), .bus_narrow(d_bus),
        .drive_pct(d_pct)
    );

    // Default-parameter instance, used for the divide ratio only
    boot_cfg_loader u_ref (
        .clk(clk), .rst_n(rst_n), .pwr_good(1'b0), .mode_in(mode_in),
        .mode_clk(r_mclk), .cfg_done(r_done), .cfg_error(r_err),
        .wb_pattern(r_wb), .clk_ratio(r_ratio), .big_endian(r_be),
        .wr_proto(r_proto), .timer_int_off(r_tmr), .bus_narrow(r_bus),
        .drive_pct(r_pct)
    );

    typedef struct packed {
        logic [3:0] wb;
        logic [3:0] ratio;
        logic       be;
        logic [1:0] proto;
        logic       tmr;
        logic       bus;
        logic [6:0] pct;
        logic       err;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [NBITS-1:0] s);
        exp_t e;
        logic [2:0] mc;
        mc      = s[7:5];
        e.wb    = s[4:1];
        e.ratio = (mc == 3'd7) ? 4'd0 : ({1'b0, mc} + 4'd2);
        e.be    = s[8];
        e.proto = s[10:9];
        e.tmr   = s[11];
        e.bus   = s[12];
        case (s[14:13])
            2'b10:   e.pct = 7'd100;
            2'b11:   e.pct = 7'd83;
            2'b00:   e.pct = 7'd67;
            default: e.pct = 7'd50;
        endcase
        e.err = s[0] | (|s[NBITS-1:15]) | (s[4:1] > 4'd8) | (mc == 3'd7) | (s[10:9] == 2'b01);
        return e;
    endfunction

    function automatic logic [NBITS-1:0] mk(input logic [3:0] wb, input logic [2:0] mc,
                                            input logic be, input logic [1:0] proto,
                                            input logic tmr, input logic bus,
                                            input logic [1:0] drv);
        logic [NBITS-1:0] s;
        s        = '0;
        s[4:1]   = wb;
        s[7:5]   = mc;
        s[8]     = be;
        s[10:9]  = proto;
        s[11]    = tmr;
        s[12]    = bus;
        s[14:13] = drv;
        return s;
    endfunction

    task automatic do_reset();
        rst_n    = 1'b0;
        pwr_good = 1'b0;
        mode_in  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(d_done == 1'b0,  "R9 reset cfg_done",  d_done,  0);
        chk(d_err == 1'b0,   "R9 reset cfg_error", d_err,   0);
        chk(d_wb == 4'd0,    "R9 reset wb",        d_wb,    0);
        chk(d_ratio == 4'd0, "R9 reset ratio",     d_ratio, 0);
        chk(d_pct == 7'd0,   "R9 reset drive",     d_pct,   0);
    endtask

    // Driver: queue the expected result, then shift the stream in
    task automatic load_stream(input logic [NBITS-1:0] s);
        sb_q.push_back(predict(s));
        @(negedge d_mclk);
        pwr_good = 1'b1;
        mode_in  = s[0];
        for (int i = 1; i < NBITS; i++) begin
            @(negedge d_mclk);
            mode_in = s[i];
        end
        @(negedge clk);
        chk(d_done == 1'b0, "R3 done not before last sample", d_done, 0);
        @(posedge d_mclk);
        @(negedge clk);
        chk(d_done == 1'b1, "R3 done at last-bit mode edge", d_done, 1);
        @(negedge clk);
    endtask

    // Monitor: compare decoded outputs when done rises
    initial begin
        forever begin
            exp_t e;
            @(posedge d_done);
            @(negedge clk);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R3 unexpected cfg_done", 1, 0);
            end else begin
                e = sb_q.pop_front();
                chk(d_wb == e.wb,       "R5 wb_pattern",    d_wb,    e.wb);
                chk(d_be == e.be,       "R5 big_endian",    d_be,    e.be);
                chk(d_proto == e.proto, "R5 wr_proto",      d_proto, e.proto);
                chk(d_tmr == e.tmr,     "R5 timer_int_off", d_tmr,   e.tmr);
                chk(d_bus == e.bus,     "R5 bus_narrow",    d_bus,   e.bus);
                chk(d_ratio == e.ratio, "R6 clk_ratio",     d_ratio, e.ratio);
                chk(d_pct == e.pct,     "R7 drive_pct",     d_pct,   e.pct);
                chk(d_err == e.err,     "R8 cfg_error",     d_err,   e.err);
            end
        end
    end

    task automatic ignore_after_done();
        logic [21:0] snap;
        logic        prev_clk;
        int          toggles;
        snap     = {d_err, d_wb, d_ratio, d_be, d_proto, d_tmr, d_bus, d_pct};
        prev_clk = d_mclk;
        toggles  = 0;
        for (int k = 0; k < 4 * (1 << FAST_LOG2); k++) begin
            @(negedge clk);
            mode_in = ~mode_in;
            if (d_mclk != prev_clk) toggles++;
            prev_clk = d_mclk;
        end
        @(negedge clk);
        chk(d_done == 1'b1, "R4 done held", d_done, 1);
        chk({d_err, d_wb, d_ratio, d_be, d_proto, d_tmr, d_bus, d_pct} == snap,
            "R4 outputs unchanged", {d_err, d_wb, d_ratio, d_be, d_proto, d_tmr, d_bus, d_pct}, snap);
        chk(toggles == 8, "R1 mode clock runs after done", toggles, 8);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        time tp0, tp1, t1, t2, t3;
        logic [NBITS-1:0] s_a, s_b, s_c, s_d;

        do_reset();

        // R2: garbage on mode_in while pwr_good is low
        mode_in = 1'b1;

        // R1: default instance period and high time
        @(posedge clk); tp0 = $time;
        @(posedge clk); tp1 = $time;
        @(posedge r_mclk); t1 = $time;
        @(negedge r_mclk); t2 = $time;
        @(posedge r_mclk); t3 = $time;
        chk((t3 - t1) == 256 * (tp1 - tp0), "R1 mode clock period", (t3 - t1) / (tp1 - tp0), 256);
        chk((t2 - t1) == 128 * (tp1 - tp0), "R1 mode clock high time", (t2 - t1) / (tp1 - tp0), 128);
        @(negedge clk);
        chk(r_done == 1'b0, "R2 no load without pwr_good", r_done, 0);
        chk(d_done == 1'b0, "R2 idle before pwr_good", d_done, 0);

        s_a = mk(4'd5, 3'd3, 1'b1, 2'b10, 1'b1, 1'b0, 2'b11);
        load_stream(s_a);
        ignore_after_done();

        do_reset();
        load_stream('0);

        do_reset();
        s_c = mk(4'd8, 3'd6, 1'b0, 2'b11, 1'b0, 1'b1, 2'b10);
        load_stream(s_c);

        do_reset();
        s_d = mk(4'd1, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01);
        load_stream(s_d);

        // R8 reserved bit and reserved codes
        do_reset();
        s_b = '0; s_b[0] = 1'b1;
        load_stream(s_b);

        do_reset();
        s_b = s_a; s_b[15] = 1'b1;
        load_stream(s_b);

        do_reset();
        s_b = s_c; s_b[NBITS-1] = 1'b1;
        load_stream(s_b);

        do_reset();
        load_stream(mk(4'd9, 3'd2, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10));

        do_reset();
        load_stream(mk(4'd3, 3'd7, 1'b1, 2'b11, 1'b0, 1'b0, 2'b00));

        do_reset();
        load_stream(mk(4'd0, 3'd1, 1'b0, 2'b01, 1'b1, 1'b1, 2'b11));

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R3 every load produced done", sb_q.size(), 0);
        finish_run();
    end

endmodule